// File: doc/BRIEF.md
# Display Raster Timing Generator

This block paces a progressive display raster from a single pixel clock. A horizontal counter steps once per pixel clock and a vertical counter steps once per finished line. From the two counts it derives a horizontal sync pulse, a vertical sync pulse, a flag marking the visible region, and the coordinates of the pixel being sent. Pixels go out left to right along a line, and lines go out top to bottom within a frame.

The default geometry is a 1680x1050 picture refreshed at about 60 Hz. Each line has 2256 pixel clocks and each frame has 1087 lines. The two syncs have opposite polarities: the horizontal pulse is active-low and the vertical pulse is active-high. For bring-up, the block also drives a 4-bit-per-channel colour output. This output shows a uniform full-green field inside the visible region and is zero everywhere else.

An asynchronous reset input, typically from a board switch, is re-timed inside the block by a two-stage synchronizer. Reset is asserted asynchronously and released synchronously. All outputs leave one bank of registers, so every output describes the same pixel on the same clock edge.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel coordinate `x_o` advances by one per pixel clock from 0 up to 2255 (1680 visible + 104 front porch + 184 sync + 288 back porch) and then returns to 0.
- R2: The line coordinate `y_o` holds for the whole of a line and advances by one on the clock where `x_o` returns to 0. After line 1086 (1050 visible + 1 + 3 + 33) it returns to 0.
- R3: `hsync_o` is 0 exactly when `x_o` lies in 1784..1967 and is 1 otherwise.
- R4: `vsync_o` is 1 exactly when `y_o` lies in 1051..1053 and is 0 otherwise.
- R5: `active_o` is 1 exactly when `x_o` < 1680 and `y_o` < 1050.
- R6: While `active_o` is 1, `red_o` = 0, `green_o` = 15 and `blue_o` = 0. While `active_o` is 0, all three channels are 0.
- R7: While `rst_n_async` is low, and immediately after it falls at any point in a clock cycle, the outputs are `x_o` = 0, `y_o` = 0, `hsync_o` = 1, `vsync_o` = 0, `active_o` = 0 and all colour channels 0.
- R8: After `rst_n_async` rises between two edges, the outputs keep their reset values through the first two rising edges. The third rising edge presents pixel (0,0), with `active_o` = 1 and the test colour, and all outputs change on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock; one count per rising edge |
| rst_n_async | input | 1 | Asynchronous active-low reset, re-timed internally |
| hsync_o | output | 1 | Horizontal sync, active-low |
| vsync_o | output | 1 | Vertical sync, active-high |
| active_o | output | 1 | High while the current pixel is in the visible region |
| x_o | output | 12 | Horizontal position of the current pixel |
| y_o | output | 11 | Vertical position of the current line |
| red_o | output | 4 | Red channel |
| green_o | output | 4 | Green channel |
| blue_o | output | 4 | Blue channel |

## Verification
Two events can fall in the same cycle. An asynchronous reset assertion can land while a counter is wrapping or while a sync pulse is active, and it must override the registered outputs at once instead of at the next edge. The bench provokes this by dropping and raising the reset at random offsets inside the cycle and at random points of the raster. After each drop it samples the outputs one time unit later. An independent model, which counts edges since release, then judges every following pixel. A second collision is the end of a line meeting the start of the vertical sync window or the end of the frame, where both counters change on the same edge. Whole frames of a reduced geometry cross these points, and the default geometry is checked along its first two full lines.

// File: rtl/raster_pkg.sv
package raster_pkg;

   typedef enum logic {
      POL_LOW  = 1'b0,
      POL_HIGH = 1'b1
   } sync_pol_e;

   // width needed to hold values 0 .. n-1
   function automatic int unsigned cnt_width(int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/raster_rst_sync.sv
module raster_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n_in,
   output logic rst_n_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("raster_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n_in) begin
      if (!rst_n_in) chain_q <= '0;
      else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/raster_axis_cnt.sv
module raster_axis_cnt #(
   parameter int unsigned TOTAL = 2256,
   parameter int unsigned W     = raster_pkg::cnt_width(TOTAL)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   localparam logic [W-1:0] LAST = W'(TOTAL - 1);

   if (TOTAL < 2) begin : g_bad_total
      $error("raster_axis_cnt: TOTAL must be at least 2");
   end
   if ((1 << W) < TOTAL) begin : g_bad_width
      $error("raster_axis_cnt: W too narrow for TOTAL");
   end

   assign wrap = step && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (wrap)  cnt <= '0;
      else if (step)  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/raster_out_stage.sv
module raster_out_stage
   import raster_pkg::*;
#(
   parameter int unsigned XW      = 12,
   parameter int unsigned YW      = 11,
   parameter int unsigned H_VIS   = 1680,
   parameter int unsigned H_FP    = 104,
   parameter int unsigned H_SYNC  = 184,
   parameter int unsigned V_VIS   = 1050,
   parameter int unsigned V_FP    = 1,
   parameter int unsigned V_SYNC  = 3,
   parameter sync_pol_e   HS_POL  = POL_LOW,
   parameter sync_pol_e   VS_POL  = POL_HIGH,
   parameter int unsigned CW      = 4,
   parameter logic [CW-1:0] TEST_R = '0,
   parameter logic [CW-1:0] TEST_G = '1,
   parameter logic [CW-1:0] TEST_B = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [XW-1:0] h_cnt,
   input  logic [YW-1:0] v_cnt,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          active_o,
   output logic [XW-1:0] x_o,
   output logic [YW-1:0] y_o,
   output logic [CW-1:0] red_o,
   output logic [CW-1:0] green_o,
   output logic [CW-1:0] blue_o
);

   localparam logic [XW-1:0] H_VIS_END = XW'(H_VIS);
   localparam logic [XW-1:0] HS_BEG    = XW'(H_VIS + H_FP);
   localparam logic [XW-1:0] HS_END    = XW'(H_VIS + H_FP + H_SYNC);
   localparam logic [YW-1:0] V_VIS_END = YW'(V_VIS);
   localparam logic [YW-1:0] VS_BEG    = YW'(V_VIS + V_FP);
   localparam logic [YW-1:0] VS_END    = YW'(V_VIS + V_FP + V_SYNC);
   localparam logic          HS_IDLE   = (HS_POL == POL_HIGH) ? 1'b0 : 1'b1;
   localparam logic          VS_IDLE   = (VS_POL == POL_HIGH) ? 1'b0 : 1'b1;

   logic in_hs, in_vs, in_vis;
   logic hs_lvl, vs_lvl;

   always_comb begin
      in_hs  = (h_cnt >= HS_BEG) && (h_cnt < HS_END);
      in_vs  = (v_cnt >= VS_BEG) && (v_cnt < VS_END);
      in_vis = (h_cnt < H_VIS_END) && (v_cnt < V_VIS_END);
   end

   if (HS_POL == POL_HIGH) begin : g_hs_high
      assign hs_lvl = in_hs;
   end else begin : g_hs_low
      assign hs_lvl = ~in_hs;
   end

   if (VS_POL == POL_HIGH) begin : g_vs_high
      assign vs_lvl = in_vs;
   end else begin : g_vs_low
      assign vs_lvl = ~in_vs;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync_o  <= HS_IDLE;
         vsync_o  <= VS_IDLE;
         active_o <= 1'b0;
         x_o      <= '0;
         y_o      <= '0;
         red_o    <= '0;
         green_o  <= '0;
         blue_o   <= '0;
      end else begin
         hsync_o  <= hs_lvl;
         vsync_o  <= vs_lvl;
         active_o <= in_vis;
         x_o      <= h_cnt;
         y_o      <= v_cnt;
         red_o    <= in_vis ? TEST_R : '0;
         green_o  <= in_vis ? TEST_G : '0;
         blue_o   <= in_vis ? TEST_B : '0;
      end
   end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import raster_pkg::*;
#(
   parameter int unsigned H_VIS      = 1680,
   parameter int unsigned H_FP       = 104,
   parameter int unsigned H_SYNC     = 184,
   parameter int unsigned H_BP       = 288,
   parameter int unsigned V_VIS      = 1050,
   parameter int unsigned V_FP       = 1,
   parameter int unsigned V_SYNC     = 3,
   parameter int unsigned V_BP       = 33,
   parameter sync_pol_e   HS_POL     = POL_LOW,
   parameter sync_pol_e   VS_POL     = POL_HIGH,
   parameter int unsigned CW         = 4,
   parameter logic [CW-1:0] TEST_R   = '0,
   parameter logic [CW-1:0] TEST_G   = '1,
   parameter logic [CW-1:0] TEST_B   = '0,
   parameter int unsigned RST_STAGES = 2,
   localparam int unsigned H_TOTAL   = H_VIS + H_FP + H_SYNC + H_BP,
   localparam int unsigned V_TOTAL   = V_VIS + V_FP + V_SYNC + V_BP,
   localparam int unsigned XW        = cnt_width(H_TOTAL),
   localparam int unsigned YW        = cnt_width(V_TOTAL)
) (
   input  logic          clk_pix,
   input  logic          rst_n_async,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          active_o,
   output logic [XW-1:0] x_o,
   output logic [YW-1:0] y_o,
   output logic [CW-1:0] red_o,
   output logic [CW-1:0] green_o,
   output logic [CW-1:0] blue_o
);

   if (H_VIS == 0 || H_SYNC == 0 || V_VIS == 0 || V_SYNC == 0) begin : g_bad_geom
      $error("raster_timing_gen: visible and sync spans must be non-zero");
   end
   if (CW == 0) begin : g_bad_cw
      $error("raster_timing_gen: CW must be non-zero");
   end

   logic          rst_q_n;
   logic [XW-1:0] h_cnt;
   logic [YW-1:0] v_cnt;
   logic          h_wrap;
   logic          v_wrap;

   raster_rst_sync #(.STAGES(RST_STAGES)) u_rst (
      .clk       (clk_pix),
      .rst_n_in  (rst_n_async),
      .rst_n_out (rst_q_n)
   );

   raster_axis_cnt #(.TOTAL(H_TOTAL), .W(XW)) u_hcnt (
      .clk   (clk_pix),
      .rst_n (rst_q_n),
      .step  (1'b1),
      .cnt   (h_cnt),
      .wrap  (h_wrap)
   );

   raster_axis_cnt #(.TOTAL(V_TOTAL), .W(YW)) u_vcnt (
      .clk   (clk_pix),
      .rst_n (rst_q_n),
      .step  (h_wrap),
      .cnt   (v_cnt),
      .wrap  (v_wrap)
   );

   raster_out_stage #(
      .XW(XW), .YW(YW),
      .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC),
      .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC),
      .HS_POL(HS_POL), .VS_POL(VS_POL), .CW(CW),
      .TEST_R(TEST_R), .TEST_G(TEST_G), .TEST_B(TEST_B)
   ) u_out (
      .clk      (clk_pix),
      .rst_n    (rst_q_n),
      .h_cnt    (h_cnt),
      .v_cnt    (v_cnt),
      .hsync_o  (hsync_o),
      .vsync_o  (vsync_o),
      .active_o (active_o),
      .x_o      (x_o),
      .y_o      (y_o),
      .red_o    (red_o),
      .green_o  (green_o),
      .blue_o   (blue_o)
   );

   logic unused_wrap;
   assign unused_wrap = v_wrap;

endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
   parameter int unsigned H_VIS = 1680,
   parameter int unsigned H_FP  = 104,
   parameter int unsigned H_SYNC = 184,
   parameter int unsigned H_TOTAL = 2256,
   parameter int unsigned V_VIS = 1050,
   parameter int unsigned V_FP  = 1,
   parameter int unsigned V_SYNC = 3,
   parameter int unsigned V_TOTAL = 1087,
   parameter int unsigned XW = 12,
   parameter int unsigned YW = 11,
   parameter int unsigned CW = 4,
   parameter logic [CW-1:0] TEST_R = '0,
   parameter logic [CW-1:0] TEST_G = '1,
   parameter logic [CW-1:0] TEST_B = '0
) (
   input logic          clk,
   input logic          rst_q_n,
   input logic          hsync_o,
   input logic          vsync_o,
   input logic          active_o,
   input logic [XW-1:0] x_o,
   input logic [YW-1:0] y_o,
   input logic [CW-1:0] red_o,
   input logic [CW-1:0] green_o,
   input logic [CW-1:0] blue_o
);

   localparam logic [XW-1:0] X_LAST = XW'(H_TOTAL - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(V_TOTAL - 1);

   logic live_q;
   always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) live_q <= 1'b0;
      else          live_q <= 1'b1;
   end

   // R1
   x_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (live_q && x_o != X_LAST) |=> (x_o == $past(x_o) + 1'b1));

   // R1
   x_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (live_q && x_o == X_LAST) |=> (x_o == '0));

   // R2
   y_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (live_q && x_o != X_LAST) |=> $stable(y_o));

   // R2
   y_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (live_q && x_o == X_LAST && y_o != Y_LAST) |=> (y_o == $past(y_o) + 1'b1));

   // R2
   y_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (live_q && x_o == X_LAST && y_o == Y_LAST) |=> (y_o == '0));

   // R3
   hs_blank_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      !hsync_o |-> !active_o);

   // R4
   vs_blank_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      vsync_o |-> !active_o);

   // R5
   act_window_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      active_o |-> (x_o < XW'(H_VIS) && y_o < YW'(V_VIS)));

   // R6
   blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      !active_o |-> (red_o == '0 && green_o == '0 && blue_o == '0));

   // R6
   test_colour_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      active_o |-> (red_o == TEST_R && green_o == TEST_G && blue_o == TEST_B));

   // R7
   always @(negedge clk) begin
      if (rst_q_n === 1'b0) begin
         rst_idle_chk: assert (x_o == '0 && y_o == '0 && !active_o && hsync_o && !vsync_o);
      end
   end

endmodule

bind raster_timing_gen raster_timing_gen_chk #(
   .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_TOTAL(H_TOTAL),
   .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_TOTAL(V_TOTAL),
   .XW(XW), .YW(YW), .CW(CW),
   .TEST_R(TEST_R), .TEST_G(TEST_G), .TEST_B(TEST_B)
) u_chk (
   .clk      (clk_pix),
   .rst_q_n  (rst_q_n),
   .hsync_o  (hsync_o),
   .vsync_o  (vsync_o),
   .active_o (active_o),
   .x_o      (x_o),
   .y_o      (y_o),
   .red_o    (red_o),
   .green_o  (green_o),
   .blue_o   (blue_o)
);

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;

   localparam int CLK_PERIOD = 10;

   // reduced geometry for whole-frame coverage
   localparam int SHV = 12, SHF = 2, SHS = 3, SHB = 4;
   localparam int SVV = 6,  SVF = 1, SVS = 2, SVB = 3;
   localparam int SHT = SHV + SHF + SHS + SHB;
   localparam int SVT = SVV + SVF + SVS + SVB;
   localparam int SXW = $clog2(SHT);
   localparam int SYW = $clog2(SVT);

   // default geometry
   localparam int FHV = 1680, FHF = 104, FHS = 184, FHB = 288;
   localparam int FVV = 1050, FVF = 1, FVS = 3, FVB = 33;
   localparam int FHT = FHV + FHF + FHS + FHB;
   localparam int FVT = FVV + FVF + FVS + FVB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic s_hs, s_vs, s_act;
   logic [SXW-1:0] s_x;
   logic [SYW-1:0] s_y;
   logic [3:0] s_r, s_g, s_b;

   logic f_hs, f_vs, f_act;
   logic [11:0] f_x;
   logic [10:0] f_y;
   logic [3:0] f_r, f_g, f_b;

   raster_timing_gen #(
      .H_VIS(SHV), .H_FP(SHF), .H_SYNC(SHS), .H_BP(SHB),
      .V_VIS(SVV), .V_FP(SVF), .V_SYNC(SVS), .V_BP(SVB)
   ) uut (
      .clk_pix(clk), .rst_n_async(rst_n),
      .hsync_o(s_hs), .vsync_o(s_vs), .active_o(s_act),
      .x_o(s_x), .y_o(s_y), .red_o(s_r), .green_o(s_g), .blue_o(s_b)
   );

   raster_timing_gen uut_full (
      .clk_pix(clk), .rst_n_async(rst_n),
      .hsync_o(f_hs), .vsync_o(f_vs), .active_o(f_act),
      .x_o(f_x), .y_o(f_y), .red_o(f_r), .green_o(f_g), .blue_o(f_b)
   );

   int vectors = 0;
   int fails = 0;
   int edges = 0;
   bit full_on = 1'b0;
   bit done = 1'b0;

   task automatic chk(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int in_range(int v, int lo, int n);
      return (v >= lo && v < lo + n) ? 1 : 0;
   endfunction

   // expected pixel for a given index of clocks since the first live edge
   function automatic void model(int idx, int hv, int hf, int hs, int ht,
                                 int vv, int vf, int vs, int vt,
                                 output int ex, output int ey, output int ehs,
                                 output int evs, output int eact);
      ex   = idx % ht;
      ey   = (idx / ht) % vt;
      ehs  = 1 - in_range(ex, hv + hf, hs);
      evs  = in_range(ey, vv + vf, vs);
      eact = (ex < hv && ey < vv) ? 1 : 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) edges <= 0;
      else        edges <= edges + 1;
   end

   task automatic check_pixel(bit full, int x, int y, int hs, int vs, int act,
                              int r, int g, int b);
      int ex, ey, ehs, evs, eact;
      if (edges < 3) begin
         // R7 while held, R8 during the two release edges
         chk(rst_n ? "R8 held x" : "R7 reset x", x, 0);
         chk(rst_n ? "R8 held y" : "R7 reset y", y, 0);
         chk(rst_n ? "R8 held hsync" : "R7 reset hsync", hs, 1);
         chk(rst_n ? "R8 held vsync" : "R7 reset vsync", vs, 0);
         chk(rst_n ? "R8 held active" : "R7 reset active", act, 0);
         chk(rst_n ? "R8 held colour" : "R7 reset colour", r + g + b, 0);
      end else begin
         if (full)
            model(edges - 3, FHV, FHF, FHS, FHT, FVV, FVF, FVS, FVT, ex, ey, ehs, evs, eact);
         else
            model(edges - 3, SHV, SHF, SHS, SHT, SVV, SVF, SVS, SVT, ex, ey, ehs, evs, eact);
         if (edges == 3) chk("R8 first live pixel active", act, 1);
         chk("R1 x", x, ex);
         chk("R2 y", y, ey);
         chk("R3 hsync", hs, ehs);
         chk("R4 vsync", vs, evs);
         chk("R5 active", act, eact);
         chk("R6 red", r, 0);
         chk("R6 green", g, eact ? 15 : 0);
         chk("R6 blue", b, 0);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check_pixel(1'b0, int'(s_x), int'(s_y), int'(s_hs), int'(s_vs), int'(s_act),
                     int'(s_r), int'(s_g), int'(s_b));
         if (full_on)
            check_pixel(1'b1, int'(f_x), int'(f_y), int'(f_hs), int'(f_vs), int'(f_act),
                        int'(f_r), int'(f_g), int'(f_b));
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual run still busy expected finished");
      finish_run();
   end

   initial begin
      int unsigned seed_val;
      seed_val = $urandom(32'd4711);
      full_on = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      #2 rst_n = 1'b1;
      // two full-size lines plus many reduced frames, crossing all wraps
      repeat (4600) @(posedge clk);
      @(negedge clk);
      full_on = 1'b0;

      // random reset pulses landing anywhere in the raster and the cycle
      for (int i = 0; i < 40; i++) begin
         int gap, off, len, rel;
         gap = 1 + int'($urandom % 500);
         off = 1 + int'($urandom % (CLK_PERIOD - 2));
         len = 1 + int'($urandom % 5);
         rel = 1 + int'($urandom % (CLK_PERIOD - 2));
         repeat (gap) @(posedge clk);
         #off rst_n = 1'b0;
         #1;
         // R7 immediate response to asynchronous assertion
         chk("R7 async x", int'(s_x), 0);
         chk("R7 async y", int'(s_y), 0);
         chk("R7 async hsync", int'(s_hs), 1);
         chk("R7 async vsync", int'(s_vs), 0);
         chk("R7 async active", int'(s_act), 0);
         chk("R7 async green", int'(s_g), 0);
         repeat (len) @(posedge clk);
         #rel rst_n = 1'b1;
      end

      repeat (2 * SHT * SVT) @(posedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule